// File: doc/BRIEF.md
# CAN Physical-Layer Mode Controller with Standby Wake Filter

This block is the digital mode logic for a CAN line interface that has a normal mode and a low-power standby mode. The host selects the mode with one input. The input is synchronized, then held in a mode register. In normal mode the transmitter is enabled, and the receive-data output follows a sampled copy of the main differential comparator.

In standby mode the transmitter is held off, so the bus stays recessive. The main comparator is ignored. The output of a low-power bus monitor is filtered instead: the receive output goes low only after the bus has stayed dominant without a break for a programmable number of clock cycles. The default is a millisecond-scale count. The host reads that low level as a wake request. The block never leaves standby by itself. It stays there until the host drives the mode input low.

Top module: `phy_mode_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `standbyActive` is 1, `txEnable` is 0 and `rxData` is 1 (recessive).
- R2: `modeSel` = 0 selects normal mode and `modeSel` = 1 selects standby. `modeSel` passes through a synchronizer of SYNC_STAGES flops (default 2) and then a mode register, so `standbyActive` follows `modeSel` SYNC_STAGES+1 clock edges after the change.
- R3: `txEnable` is 0 whenever `standbyActive` is 1 and is 1 whenever `standbyActive` is 0.
- R4: In normal mode, `rxData` equals the value `mainRxBit` had at the previous clock edge (0 = dominant, 1 = recessive).
- R5: In standby, `rxData` goes low only after `lowPwrRxBit` (0 = dominant) has been 0 at FILTER_CYCLES consecutive samples. With `lowPwrRxBit` held low from just before edge 1, `rxData` falls after edge FILTER_CYCLES+1 and not earlier.
- R6: In standby, one recessive sample of `lowPwrRxBit` before the count completes restarts the count from zero, so a dominant period broken by a single recessive sample raises no wake.
- R7: After a wake, `rxData` returns to 1 two edges after `lowPwrRxBit` returns to 1. Another wake needs a new, full-length dominant period.
- R8: A wake indication never changes the mode. `standbyActive` stays 1 until `modeSel` is driven low.
- R9: Leaving standby clears the filter count and the wake indication. When standby is entered again with the bus still dominant, the full FILTER_CYCLES count starts only from the edge at which `standbyActive` rises.
- R10: In standby, `mainRxBit` has no effect on `rxData`. In normal mode, `lowPwrRxBit` has no effect on `rxData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| modeSel | input | 1 | Mode request: 0 normal, 1 standby (asynchronous) |
| mainRxBit | input | 1 | Main differential receiver result, 0 dominant |
| lowPwrRxBit | input | 1 | Low-power standby monitor result, 0 dominant |
| rxData | output | 1 | Receive data to the protocol controller, 0 dominant / wake |
| txEnable | output | 1 | Transmitter enable, 1 allows driving the bus |
| standbyActive | output | 1 | Current mode, 1 in standby |

## Verification
Some rules are checked by the bound assertions on every cycle. The transmitter stays off whenever the block is in standby (R3). Normal-mode receive data is the previous main-receiver sample (R4). Every mode change follows a request seen SYNC_STAGES+1 edges earlier (R2, R8). A standby wake level is only ever present while the monitor input was dominant two edges before (R5). Other behaviours can only be shown by the bench scenarios, because they depend on the length of a whole pulse: the exact edge at which a wake appears, the restart of the count after a recessive sample, the release and re-arm after a wake, and the clearing of the filter on leaving standby. The bench sweeps dominant pulse lengths around the filter length for that.

// File: rtl/phy_mode_pkg.sv
package phy_mode_pkg;

  // Strobes from the mode control to the receive datapath
  typedef struct packed {
    logic standby;      // current registered mode, 1 = standby
    logic clearFilter;  // one-cycle pulse on standby -> normal
  } modeStrobes_t;

  function automatic int unsigned cntWidth(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/mode_ctrl_unit.sv
module mode_ctrl_unit
  import phy_mode_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         modeSel,
  output modeStrobes_t strobes
);

  localparam int unsigned LAST_STAGE = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   modeReg;
  logic                   modeSync;

  // Synchronizer chain, reset to the standby request
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : gSync
      if (gi == 0) begin : gFirst
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncChain[gi] <= 1'b1;
          else        syncChain[gi] <= modeSel;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncChain[gi] <= 1'b1;
          else        syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  assign modeSync = syncChain[LAST_STAGE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) modeReg <= 1'b1;
    else        modeReg <= modeSync;
  end

  always_comb begin
    strobes.standby     = modeReg;
    strobes.clearFilter = modeReg & ~modeSync;
  end

endmodule

// File: rtl/rx_path_unit.sv
module rx_path_unit
  import phy_mode_pkg::*;
#(
  parameter int unsigned FILTER_CYCLES = 48000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  modeStrobes_t strobes,
  input  logic         mainRxBit,
  input  logic         lowPwrRxBit,
  output logic         rxData,
  output logic         txEnable
);

  localparam int unsigned CW = cntWidth(FILTER_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILTER_CYCLES - 1);

  logic          mainRxQ;
  logic          lowRxQ;
  logic [CW-1:0] domCount;
  logic          wakeFlag;

  // Input sample registers, recessive at reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mainRxQ <= 1'b1;
      lowRxQ  <= 1'b1;
    end else begin
      mainRxQ <= mainRxBit;
      lowRxQ  <= lowPwrRxBit;
    end
  end

  // Dominant-duration filter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      domCount <= '0;
      wakeFlag <= 1'b0;
    end else if (strobes.clearFilter) begin
      domCount <= '0;
      wakeFlag <= 1'b0;
    end else if (strobes.standby) begin
      if (lowRxQ) begin
        domCount <= '0;
        wakeFlag <= 1'b0;
      end else if (!wakeFlag) begin
        if (domCount == CNT_LAST) begin
          domCount <= '0;
          wakeFlag <= 1'b1;
        end else begin
          domCount <= domCount + 1'b1;
        end
      end
    end
  end

  always_comb begin
    rxData   = strobes.standby ? ~wakeFlag : mainRxQ;
    txEnable = ~strobes.standby;
  end

endmodule

// File: rtl/phy_mode_ctrl.sv
module phy_mode_ctrl
  import phy_mode_pkg::*;
#(
  parameter int unsigned FILTER_CYCLES = 48000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic modeSel,
  input  logic mainRxBit,
  input  logic lowPwrRxBit,
  output logic rxData,
  output logic txEnable,
  output logic standbyActive
);

  modeStrobes_t strobes;

  mode_ctrl_unit #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .modeSel(modeSel),
    .strobes(strobes)
  );

  rx_path_unit #(
    .FILTER_CYCLES(FILTER_CYCLES)
  ) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .mainRxBit  (mainRxBit),
    .lowPwrRxBit(lowPwrRxBit),
    .rxData     (rxData),
    .txEnable   (txEnable)
  );

  assign standbyActive = strobes.standby;

endmodule

// File: rtl/phy_mode_ctrl_checker.sv
module phy_mode_ctrl_checker #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic modeSel,
  input logic mainRxBit,
  input logic lowPwrRxBit,
  input logic rxData,
  input logic txEnable,
  input logic standbyActive
);

  localparam int unsigned MODE_LAT = SYNC_STAGES + 1;

  // R3: transmitter off in standby
  assert_tx_off_standby_R3: assert property (@(posedge clk) disable iff (!rst_n)
    standbyActive |-> !txEnable);

  // R3: transmitter on in normal mode
  assert_tx_on_normal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !standbyActive |-> txEnable);

  // R4: normal-mode receive data is last main receiver sample
  assert_normal_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !standbyActive |-> (rxData == $past(mainRxBit)));

  // R8: leaving standby only on a low request
  assert_leave_on_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(standbyActive) |-> ($past(modeSel, MODE_LAT) == 1'b0));

  // R2: entering standby only on a high request
  assert_enter_on_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standbyActive) |-> ($past(modeSel, MODE_LAT) == 1'b1));

  // R5: a wake level needs a dominant monitor sample behind it
  assert_wake_needs_dominant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (standbyActive && $past(standbyActive) && !rxData) |-> ($past(lowPwrRxBit, 2) == 1'b0));

endmodule

bind phy_mode_ctrl phy_mode_ctrl_checker #(
  .SYNC_STAGES(SYNC_STAGES)
) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .modeSel      (modeSel),
  .mainRxBit    (mainRxBit),
  .lowPwrRxBit  (lowPwrRxBit),
  .rxData       (rxData),
  .txEnable     (txEnable),
  .standbyActive(standbyActive)
);

// File: tb/phy_mode_ctrl_tb.sv
module phy_mode_ctrl_tb;

  localparam int F   = 8;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic modeSel = 1'b1;
  logic mainRxBit = 1'b1;
  logic lowPwrRxBit = 1'b1;
  logic rxData, txEnable, standbyActive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  phy_mode_ctrl #(.FILTER_CYCLES(F), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .modeSel(modeSel), .mainRxBit(mainRxBit),
    .lowPwrRxBit(lowPwrRxBit), .rxData(rxData), .txEnable(txEnable),
    .standbyActive(standbyActive)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive a dominant monitor pulse of length len and compare the first wake index
  task automatic pulse_sweep(input int len);
    int firstLow = -1;
    int expFirst = (len >= F) ? F + 1 : -1;
    lowPwrRxBit = 1'b0;
    for (int i = 1; i <= len + 3; i++) begin
      @(negedge clk);
      if (!rxData && firstLow < 0) firstLow = i;
      lowPwrRxBit = (i < len) ? 1'b0 : 1'b1;
    end
    check(firstLow == expFirst, "R5 wake index", firstLow, expFirst);
    check(rxData == 1'b1, "R7 release after pulse", rxData, 1);
    check(standbyActive == 1'b1, "R8 mode kept", standbyActive, 1);
  endtask

  initial begin
    tick(2);
    check(standbyActive && !txEnable && rxData, "R1 reset state",
          {standbyActive, txEnable, rxData}, 3'b101);
    rst_n = 1'b1;
    tick(1);
    check(standbyActive && !txEnable && rxData, "R1 after release",
          {standbyActive, txEnable, rxData}, 3'b101);

    // R10: main receiver ignored in standby
    for (int i = 0; i < 6; i++) begin
      mainRxBit = i[0];
      tick(1);
      check(rxData == 1'b1, "R10 main ignored in standby", rxData, 1);
    end
    mainRxBit = 1'b1;

    // R5/R6/R7: sweep pulse lengths around the filter length
    for (int len = 1; len <= F + 3; len++) pulse_sweep(len);

    // R6: broken dominant period raises no wake
    begin
      int lowSeen = 0;
      for (int i = 0; i < 2 * F + 4; i++) begin
        lowPwrRxBit = (i == F - 1) ? 1'b1 : (i < 2 * F - 2 ? 1'b0 : 1'b1);
        tick(1);
        if (!rxData) lowSeen++;
      end
      check(lowSeen == 0, "R6 restart on recessive sample", lowSeen, 0);
    end

    // R7: after wake, a second wake needs the full period again
    lowPwrRxBit = 1'b0;
    tick(F + 1);
    check(rxData == 1'b0, "R7 first wake", rxData, 0);
    lowPwrRxBit = 1'b1;
    tick(1);
    lowPwrRxBit = 1'b0;
    tick(F);
    check(rxData == 1'b1, "R7 re-arm needs full period", rxData, 1);
    tick(1);
    check(rxData == 1'b0, "R7 second wake", rxData, 0);
    tick(20);
    check(standbyActive == 1'b1, "R8 no self exit", standbyActive, 1);

    // R2: standby -> normal latency, bus still dominant at the monitor
    modeSel = 1'b0;
    tick(LAT - 1);
    check(standbyActive == 1'b1, "R2 still standby", standbyActive, 1);
    tick(1);
    check(standbyActive == 1'b0, "R2 normal after latency", standbyActive, 0);
    check(txEnable == 1'b1, "R3 tx enabled in normal", txEnable, 1);

    // R4/R10: normal mode follows main receiver, monitor ignored
    for (int i = 0; i < 16; i++) begin
      mainRxBit   = i[1] ^ i[0];
      lowPwrRxBit = i[2];
      tick(1);
      check(rxData == (i[1] ^ i[0]), "R4 follow main receiver", rxData, i[1] ^ i[0]);
    end
    mainRxBit = 1'b1;
    lowPwrRxBit = 1'b0;
    tick(F + 4);
    check(rxData == 1'b1, "R10 monitor ignored in normal", rxData, 1);

    // R9: re-enter standby with the bus dominant, count must start fresh
    modeSel = 1'b1;
    tick(LAT);
    check(standbyActive == 1'b1, "R2 standby after latency", standbyActive, 1);
    check(txEnable == 1'b0, "R3 tx off in standby", txEnable, 0);
    check(rxData == 1'b1, "R9 wake cleared", rxData, 1);
    tick(F - 1);
    check(rxData == 1'b1, "R9 no early wake", rxData, 1);
    tick(1);
    check(rxData == 1'b0, "R9 wake after fresh count", rxData, 0);

    // R9: exit during a partial count, come back, count restarts
    lowPwrRxBit = 1'b1;
    tick(3);
    lowPwrRxBit = 1'b0;
    tick(F / 2);
    modeSel = 1'b0;
    tick(LAT);
    check(standbyActive == 1'b0, "R9 normal again", standbyActive, 0);
    modeSel = 1'b1;
    tick(LAT + F - 1);
    check(rxData == 1'b1, "R9 partial count discarded", rxData, 1);
    tick(1);
    check(rxData == 1'b0, "R9 full count after return", rxData, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule